// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block decides when the system is held in reset. Three causes feed it: the chip coming out of power-on, the main supply sitting below its trip level, and a watchdog that the host must keep restarting. The analog comparators are outside the block. It sees their results as the digital flags `vlow` (supply below trip) and `valive` (supply present). All long intervals are counted in ticks from a slow timebase pulse `tick`. The defaults assume one tick per millisecond.

After every cause has cleared, reset stays active for a fixed hold-off of `HOLD_TICKS` ticks. The host restarts the watchdog only with a high-to-low edge on the shared chip-select/watchdog pin. A 2-bit selection picks one of three timeouts or turns the watchdog off. While the system runs from its backup battery, the watchdog count is frozen. A separate active-low warning output falls as soon as the supply is seen below trip. Reset follows `LEAD_CYC` clock cycles later, which gives the host a short early notice.

Top module: `supv_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_hi` is 1, `rst_lo_n` is 0 and `warn_n` is 0. At all times `rst_lo_n` equals the inverse of `rst_hi`.
- R2: After `por_n` rises with no cause present, reset is released on the `HOLD_TICKS`-th tick edge that follows, and not before.
- R3: `valive` low asserts reset at the next clock edge.
- R4: `warn_n` goes to 0 at the first clock edge that samples `vlow` high. It returns to 1 at the first edge that samples `vlow` low.
- R5: When `vlow` stays high, reset asserts exactly `LEAD_CYC` clock cycles after `warn_n` falls. A `vlow` pulse shorter than `LEAD_CYC` cycles moves only `warn_n` and leaves reset inactive.
- R6: Once every cause has cleared, reset stays active for `HOLD_TICKS` ticks. Any cause that appears during this hold-off restarts the count from zero. This applies after a watchdog reset as well.
- R7: `wd_sel` encodes the timeout as follows: 0 gives `WD_A` ticks, 1 gives `WD_B` ticks, 2 gives `WD_C` ticks, and 3 turns the watchdog off. When the count since the last restart reaches the selected limit, reset asserts at the next clock edge.
- R8: Only a 1-to-0 transition on `csn_wdi` restarts the watchdog count. A rising edge does not restart it. Holding the pin steadily low or steadily high lets the count run to a timeout.
- R9: While `backup` is 1, the watchdog count does not advance. Counting resumes when `backup` returns to 0.
- R10: With `wd_sel` = 3, no watchdog reset ever occurs. The watchdog count is held at zero while reset is active, so a full timeout period starts at every release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | One-cycle timebase pulse |
| vlow | input | 1 | Main supply below trip level |
| valive | input | 1 | Main supply present |
| csn_wdi | input | 1 | Shared chip-select / watchdog restart pin |
| wd_sel | input | 2 | Watchdog timeout selection |
| backup | input | 1 | Running from the backup battery |
| rst_hi | output | 1 | Reset, active high |
| rst_lo_n | output | 1 | Reset, active low |
| warn_n | output | 1 | Early low-supply warning, active low |

## Verification
The bench sets `HOLD_TICKS` = 6, the three timeouts to 5, 9 and 14, and `LEAD_CYC` = 2, with `tick` high on every cycle. With these values, every hold-off and every timeout finishes within a few dozen cycles. The bench can therefore predict each edge exactly. It walks through all three timeout selections, restarts the hold-off in the middle, and compares a steady-low pin against a rising edge. The lead gap and the short-pulse filter on the supply flag are also reachable at this scale.

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int HOLD_TICKS = 150,
  parameter int WD_A       = 150,
  parameter int WD_B       = 400,
  parameter int WD_C       = 800,
  parameter int LEAD_CYC   = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       vlow,
  input  logic       valive,
  input  logic       csn_wdi,
  input  logic [1:0] wd_sel,
  input  logic       backup,
  output logic       rst_hi,
  output logic       rst_lo_n,
  output logic       warn_n
);

  localparam int MAXT = (WD_C > HOLD_TICKS) ? WD_C : HOLD_TICKS;
  localparam int CW   = $clog2(MAXT + 2);
  localparam int LW   = $clog2(LEAD_CYC + 1);

  logic          rst_q, cs_q, uv;
  logic [LW-1:0] uv_cnt;
  logic [CW-1:0] hold_cnt, wd_cnt, wd_lim;
  logic          wd_off, fall, wd_exp, cause;

  assign uv = (uv_cnt == LW'(LEAD_CYC));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      uv_cnt <= '0;
      warn_n <= 1'b0;
    end else begin
      warn_n <= ~vlow;
      if (!vlow)   uv_cnt <= '0;
      else if (!uv) uv_cnt <= uv_cnt + 1'b1;
    end

  always_comb
    case (wd_sel)
      2'd0:    wd_lim = CW'(WD_A);
      2'd1:    wd_lim = CW'(WD_B);
      default: wd_lim = CW'(WD_C);
    endcase

  assign wd_off = (wd_sel == 2'd3);
  assign fall   = cs_q & ~csn_wdi;
  assign wd_exp = !wd_off && (wd_cnt >= wd_lim);
  assign cause  = !valive | uv | wd_exp;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cs_q   <= 1'b1;
      wd_cnt <= '0;
    end else begin
      cs_q <= csn_wdi;
      if (rst_q || wd_off || fall) wd_cnt <= '0;
      else if (tick && !backup)    wd_cnt <= wd_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (cause) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q && tick) begin
      if (hold_cnt == CW'(HOLD_TICKS - 1)) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end

  assign rst_hi   = rst_q;
  assign rst_lo_n = ~rst_q;

  a_r5_warn_before_reset: assert property (@(posedge clk) disable iff (!por_n)
    uv |-> !warn_n);

  a_r6_hold_bounded: assert property (@(posedge clk) disable iff (!por_n)
    hold_cnt < CW'(HOLD_TICKS));

  a_r2_release_after_hold: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> ($past(tick) && $past(hold_cnt) == CW'(HOLD_TICKS - 1)));

  a_r7_expiry_resets: assert property (@(posedge clk) disable iff (!por_n)
    wd_exp |=> rst_q);

  a_r9_backup_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (backup && !rst_q && !fall && !wd_off) |=> $stable(wd_cnt));

  a_r10_off_no_count: assert property (@(posedge clk) disable iff (!por_n)
    wd_off |=> (wd_cnt == '0));

endmodule

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6, WA = 5, WB = 9, WC = 14, LEAD = 2;

  logic clk = 1'b0, por_n = 1'b0, tick = 1'b1, vlow = 1'b0, valive = 1'b1;
  logic csn_wdi = 1'b1, backup = 1'b0;
  logic [1:0] wd_sel = 2'd3;
  logic rst_hi, rst_lo_n, warn_n;

  typedef struct { string tag; logic rst; logic chk_warn; logic warn; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_gen #(.HOLD_TICKS(HOLD), .WD_A(WA), .WD_B(WB), .WD_C(WC), .LEAD_CYC(LEAD)) u0 (
    .clk(clk), .por_n(por_n), .tick(tick), .vlow(vlow), .valive(valive),
    .csn_wdi(csn_wdi), .wd_sel(wd_sel), .backup(backup),
    .rst_hi(rst_hi), .rst_lo_n(rst_lo_n), .warn_n(warn_n));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rst(input string tag, input logic r);
    exp_t e; e.tag = tag; e.rst = r; e.chk_warn = 1'b0; e.warn = 1'b1;
    q.push_back(e);
  endtask

  task automatic expect_both(input string tag, input logic r, input logic w);
    exp_t e; e.tag = tag; e.rst = r; e.chk_warn = 1'b1; e.warn = w;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      e = q.pop_front();
      checks++;
      if (rst_hi !== e.rst || rst_lo_n !== ~e.rst) begin
        errors++;
        $display("FAIL %s: rst_hi=%b rst_lo_n=%b expected rst_hi=%b", e.tag, rst_hi, rst_lo_n, e.rst);
      end
      if (e.chk_warn) begin
        checks++;
        if (warn_n !== e.warn) begin
          errors++;
          $display("FAIL %s: warn_n=%b expected %b", e.tag, warn_n, e.warn);
        end
      end
    end
  end

  task automatic kick();
    csn_wdi = 1'b1; step(1);
    csn_wdi = 1'b0; step(1);
    csn_wdi = 1'b1;
  endtask

  task automatic expire(input logic [1:0] sel, input int lim);
    wd_sel = sel;
    kick();
    step(lim);  expect_rst("R7 no reset at limit sample", 1'b0);
    step(1);    expect_rst("R7 reset after timeout", 1'b1);
    step(HOLD); expect_rst("R6 hold-off after watchdog", 1'b1);
    step(1);    expect_rst("R6 released after watchdog", 1'b0);
    step(lim);  expect_rst("R10 full period after release", 1'b0);
    step(1);    expect_rst("R10 timeout after full period", 1'b1);
    step(HOLD + 1); expect_rst("R6 released again", 1'b0);
  endtask

  initial begin
    step(3); expect_both("R1 power-on state", 1'b1, 1'b0);
    por_n = 1'b1;
    step(HOLD - 1); expect_rst("R2 still held before hold-off ends", 1'b1);
    step(1);        expect_both("R2 released after hold-off", 1'b0, 1'b1);

    valive = 1'b0; step(1); expect_rst("R3 supply lost", 1'b1);
    valive = 1'b1;
    step(HOLD - 1); expect_rst("R3 held", 1'b1);
    step(1);        expect_rst("R3 released", 1'b0);

    vlow = 1'b1;
    step(1);        expect_both("R4 warning falls first", 1'b0, 1'b0);
    step(LEAD - 1); expect_rst("R5 reset not yet", 1'b0);
    step(1);        expect_both("R5 reset after lead", 1'b1, 1'b0);
    vlow = 1'b0;
    step(1);        expect_both("R4 warning returns", 1'b1, 1'b1);
    step(HOLD - 1); expect_rst("R6 hold-off after undervoltage", 1'b1);
    step(1);        expect_rst("R6 released after undervoltage", 1'b0);

    vlow = 1'b1; step(LEAD - 1); expect_both("R5 short dip warns", 1'b0, 1'b0);
    vlow = 1'b0; step(2);        expect_both("R5 short dip no reset", 1'b0, 1'b1);

    valive = 1'b0; step(1); valive = 1'b1;
    step(HOLD - 2);
    valive = 1'b0; step(1); valive = 1'b1;
    step(HOLD - 1); expect_rst("R6 restarted hold-off", 1'b1);
    step(1);        expect_rst("R6 released after restart", 1'b0);

    expire(2'd0, WA);
    expire(2'd1, WB);
    expire(2'd2, WC);

    wd_sel = 2'd0;
    kick();
    step(WA - 1);
    csn_wdi = 1'b0; step(1); expect_rst("R8 falling edge restarts", 1'b0);
    step(WA - 1);            expect_rst("R8 restart extended period", 1'b0);
    csn_wdi = 1'b1; step(1); expect_rst("R8 at limit", 1'b0);
    step(1);                 expect_rst("R8 rising edge and steady low do not restart", 1'b1);
    step(HOLD + 3);          expect_rst("R8 released", 1'b0);

    kick();
    backup = 1'b1; step(WA * 3); expect_rst("R9 frozen in backup", 1'b0);
    backup = 1'b0; step(WA);     expect_rst("R9 resumed not yet expired", 1'b0);
    step(1);                     expect_rst("R9 expires after resume", 1'b1);
    step(HOLD + 3);              expect_rst("R9 released", 1'b0);

    wd_sel = 2'd3;
    step(WC * 3); expect_rst("R10 disabled never resets", 1'b0);

    step(1);
    wait (q.size() == 0);
    step(1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule